// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is an 18-bit first-in first-out buffer with separate write and read clocks. The two clocks may be unrelated, or they may be one clock. A write is accepted on a rising write-clock edge when the active-low write enable is asserted, the active-low load strobe is not asserted and the buffer has room. A read moves the oldest word from the storage array into a registered output on a rising read-clock edge. Data never falls through: every word, including the first word written into an empty buffer, appears at the output only after an explicit read request.

Five active-low status flags report occupancy. The write clock updates full, almost-full and half-full. The read clock updates empty and almost-empty. The almost-empty threshold n and the almost-full threshold m arrive as plain inputs from a neighbouring offset register block. Each pointer is a binary counter one bit wider than the address. It crosses to the other clock domain as Gray code through two flops. Flags driven by the other side's activity therefore release late, never early. When the parameter `TIE_CLOCKS` is set, both clocks must be one net and the synchronisers are left out.

An asynchronous active-low reset puts both pointers at the first location, clears the output register and sets the flags to their empty-buffer values.

Top module: `prog_flag_fifo`

## Requirements
- R1: With `load_ni` high and the buffer not full, a low `wen_ni` at a rising `wclk_i` edge stores `wdata_i` and advances the write pointer by one.
- R2: With no reads after reset, `full_no` goes low after exactly DEPTH accepted writes. While it is low, writes are ignored whatever `wen_ni` does, and no ignored word is ever read out.
- R3: With `load_ni` high and the buffer not empty, a low `ren_ni` at a rising `rclk_i` edge loads the oldest word into `rdata_o`. Without such a read `rdata_o` holds its value, including after a word is written into an empty buffer.
- R4: `empty_no` goes low once the last stored word has been read. While it is low, reads are ignored and `rdata_o` holds the last word read.
- R5: Once settled, `aempty_no` is low exactly when the occupancy is between 0 and n, where n is `empty_ofs_i`.
- R6: Once settled, `afull_no` is low exactly when the occupancy is between DEPTH-m and DEPTH, where m is `full_ofs_i`.
- R7: Once settled, `half_no` is low exactly when more than DEPTH/2 words are stored.
- R8: While `rst_ni` is low, `full_no`, `half_no` and `afull_no` are high, `empty_no` and `aempty_no` are low, `rdata_o` is zero and the buffer holds no words.
- R9: While `load_ni` is low, neither port transfers data: the flags, the stored contents and `rdata_o` stay unchanged.
- R10: Words leave in the order they were accepted, also when a write and a read happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock (the same net as wclk_i when TIE_CLOCKS=1) |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| wen_ni | input | 1 | Write request, active low |
| ren_ni | input | 1 | Read request, active low |
| load_ni | input | 1 | Load strobe, active low; blocks data transfer while low |
| wdata_i | input | DATA_W | Write data |
| empty_ofs_i | input | OFS_W | Almost-empty threshold n |
| full_ofs_i | input | OFS_W | Almost-full threshold m |
| rdata_o | output | DATA_W | Registered read data |
| full_no | output | 1 | Full flag, active low |
| afull_no | output | 1 | Almost-full flag, active low |
| half_no | output | 1 | Half-full flag, active low |
| empty_no | output | 1 | Empty flag, active low |
| aempty_no | output | 1 | Almost-empty flag, active low |

## Verification
A write or read pointer off by one shows at the ports in two ways. A full or empty flag arrives one transfer early or late, which the burst sequences catch right at the boundary words. A word comes out of order, duplicated or lost, which the reference queue flags on the first affected read. A wrong threshold comparison or a broken synchroniser leaves a flag at the wrong level after the bench has let both domains settle. Such a fault is found at the next settled flag check, because these checks sit exactly on either side of each threshold.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef struct packed {
    logic full_n;
    logic afull_n;
    logic half_n;
  } wflags_t;

  typedef struct packed {
    logic empty_n;
    logic aempty_n;
  } rflags_t;
endpackage

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
  parameter int W      = 9,
  parameter bit BYPASS = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_s;

  generate
    if (BYPASS) begin : g_tied
      assign gray_s = gray_i;
    end else begin : g_sync
      logic [W-1:0] stg1_q, stg2_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg1_q <= '0;
          stg2_q <= '0;
        end else begin
          stg1_q <= gray_i;
          stg2_q <= stg1_q;
        end
      end
      assign gray_s = stg2_q;
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(gray_s >> i);
  end
endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PTR_W = 9,
  parameter int OFS_W = 12
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             wen_ni,
  input  logic             load_ni,
  input  logic [OFS_W-1:0] full_ofs_i,
  input  logic [PTR_W-1:0] rptr_i,
  output logic [PTR_W-1:0] wptr_o,
  output logic [PTR_W-1:0] wgray_o,
  output logic             we_o,
  output wflags_t          flags_o
);
  localparam int CMP_W = ((PTR_W > OFS_W) ? PTR_W : OFS_W) + 1;

  logic [PTR_W-1:0] wptr_q, wptr_nxt, cnt_nxt;
  logic [CMP_W-1:0] cnt_x;
  wflags_t          flags_d;

  assign we_o     = !wen_ni && load_ni && flags_o.full_n;
  assign wptr_nxt = wptr_q + PTR_W'(we_o);
  assign cnt_nxt  = wptr_nxt - rptr_i;
  assign cnt_x    = CMP_W'(cnt_nxt);

  always_comb begin
    flags_d.full_n  = !(cnt_x == CMP_W'(DEPTH));
    flags_d.afull_n = !((cnt_x + CMP_W'(full_ofs_i)) >= CMP_W'(DEPTH));
    flags_d.half_n  = !(cnt_x > CMP_W'(DEPTH / 2));
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_o <= '0;
      flags_o <= '{full_n: 1'b1, afull_n: 1'b1, half_n: 1'b1};
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_o <= wptr_nxt ^ (wptr_nxt >> 1);
      flags_o <= flags_d;
    end
  end

  assign wptr_o = wptr_q;
endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
  import fifo_pkg::*;
#(
  parameter int PTR_W = 9,
  parameter int OFS_W = 12
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             ren_ni,
  input  logic             load_ni,
  input  logic [OFS_W-1:0] empty_ofs_i,
  input  logic [PTR_W-1:0] wptr_i,
  output logic [PTR_W-1:0] rptr_o,
  output logic [PTR_W-1:0] rgray_o,
  output logic             re_o,
  output rflags_t          flags_o
);
  localparam int CMP_W = ((PTR_W > OFS_W) ? PTR_W : OFS_W) + 1;

  logic [PTR_W-1:0] rptr_q, rptr_nxt, cnt_nxt;
  logic [CMP_W-1:0] cnt_x;
  rflags_t          flags_d;

  assign re_o     = !ren_ni && load_ni && flags_o.empty_n;
  assign rptr_nxt = rptr_q + PTR_W'(re_o);
  assign cnt_nxt  = wptr_i - rptr_nxt;
  assign cnt_x    = CMP_W'(cnt_nxt);

  always_comb begin
    flags_d.empty_n  = (cnt_x != '0);
    flags_d.aempty_n = !(cnt_x <= CMP_W'(empty_ofs_i));
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_o <= '0;
      flags_o <= '{empty_n: 1'b0, aempty_n: 1'b0};
    end else begin
      rptr_q  <= rptr_nxt;
      rgray_o <= rptr_nxt ^ (rptr_nxt >> 1);
      flags_o <= flags_d;
    end
  end

  assign rptr_o = rptr_q;
endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo
  import fifo_pkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int DEPTH      = 256,
  parameter int OFS_W      = 12,
  parameter bit TIE_CLOCKS = 1'b0
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen_ni,
  input  logic              ren_ni,
  input  logic              load_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [OFS_W-1:0]  empty_ofs_i,
  input  logic [OFS_W-1:0]  full_ofs_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_no,
  output logic              afull_no,
  output logic              half_no,
  output logic              empty_no,
  output logic              aempty_no
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  logic [PTR_W-1:0] wptr_bin, wgray, rptr_bin, rgray;
  logic [PTR_W-1:0] rptr_in_w, wptr_in_r;
  logic             we, re;
  wflags_t          wflags;
  rflags_t          rflags;

  fifo_ptr_sync #(.W(PTR_W), .BYPASS(TIE_CLOCKS)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .gray_i(rgray), .bin_o(rptr_in_w)
  );

  fifo_ptr_sync #(.W(PTR_W), .BYPASS(TIE_CLOCKS)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .gray_i(wgray), .bin_o(wptr_in_r)
  );

  fifo_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .OFS_W(OFS_W)) u_wr (
    .wclk_i    (wclk_i),
    .rst_ni    (rst_ni),
    .wen_ni    (wen_ni),
    .load_ni   (load_ni),
    .full_ofs_i(full_ofs_i),
    .rptr_i    (rptr_in_w),
    .wptr_o    (wptr_bin),
    .wgray_o   (wgray),
    .we_o      (we),
    .flags_o   (wflags)
  );

  fifo_rd_ctrl #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_rd (
    .rclk_i     (rclk_i),
    .rst_ni     (rst_ni),
    .ren_ni     (ren_ni),
    .load_ni    (load_ni),
    .empty_ofs_i(empty_ofs_i),
    .wptr_i     (wptr_in_r),
    .rptr_o     (rptr_bin),
    .rgray_o    (rgray),
    .re_o       (re),
    .flags_o    (rflags)
  );

  fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(wptr_bin[ADDR_W-1:0]),
    .wdata_i(wdata_i),
    .rclk_i (rclk_i),
    .rst_ni (rst_ni),
    .re_i   (re),
    .raddr_i(rptr_bin[ADDR_W-1:0]),
    .rdata_o(rdata_o)
  );

  assign full_no   = wflags.full_n;
  assign afull_no  = wflags.afull_n;
  assign half_no   = wflags.half_n;
  assign empty_no  = rflags.empty_n;
  assign aempty_no = rflags.aempty_n;
endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
  parameter int DATA_W = 18,
  parameter int PTR_W  = 9
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              wen_ni,
  input logic              ren_ni,
  input logic              load_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              full_no,
  input logic              afull_no,
  input logic              half_no,
  input logic              empty_no,
  input logic              aempty_no,
  input logic [PTR_W-1:0]  wptr_i,
  input logic [PTR_W-1:0]  rptr_i
);
  // R1
  wr_advance_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wen_ni && load_ni && full_no) |=> (wptr_i == $past(wptr_i) + PTR_W'(1)));

  // R2
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |=> $stable(wptr_i));

  // R3
  rd_advance_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!ren_ni && load_ni && empty_no) |=> (rptr_i == $past(rptr_i) + PTR_W'(1)));

  // R4
  no_underflow_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> ($stable(rdata_o) && $stable(rptr_i)));

  // R5
  empty_in_aempty_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !aempty_no);

  // R6
  full_in_afull_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !afull_no);

  // R7
  full_in_half_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !half_no);

  // R9
  load_blocks_wr_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !load_ni |=> $stable(wptr_i));

  // R9
  load_blocks_rd_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !load_ni |=> ($stable(rdata_o) && $stable(rptr_i)));
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .wen_ni   (wen_ni),
  .ren_ni   (ren_ni),
  .load_ni  (load_ni),
  .rdata_o  (rdata_o),
  .full_no  (full_no),
  .afull_no (afull_no),
  .half_no  (half_no),
  .empty_no (empty_no),
  .aempty_no(aempty_no),
  .wptr_i   (wptr_bin),
  .rptr_i   (rptr_bin)
);

// File: tb/prog_flag_fifo_bench.sv
module prog_flag_fifo_bench;
  localparam int DATA_W = 18;
  localparam int DEPTH  = 256;
  localparam int OFS_W  = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wen_ni = 1'b1, ren_ni = 1'b1, load_ni = 1'b1;
  logic [DATA_W-1:0] wdata = '0;
  logic [OFS_W-1:0]  n_ofs = 12'd5, m_ofs = 12'd10;
  logic [DATA_W-1:0] rdata;
  logic              full_no, afull_no, half_no, empty_no, aempty_no;

  int total = 0;
  int bad   = 0;
  logic [DATA_W-1:0] model_q [$];
  logic [DATA_W-1:0] last_rd = '0;

  always #2 clk = ~clk;

  prog_flag_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .OFS_W(OFS_W), .TIE_CLOCKS(1'b0)) u_prog_flag_fifo (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni),
    .wen_ni(wen_ni), .ren_ni(ren_ni), .load_ni(load_ni),
    .wdata_i(wdata), .empty_ofs_i(n_ofs), .full_ofs_i(m_ofs),
    .rdata_o(rdata), .full_no(full_no), .afull_no(afull_no), .half_no(half_no),
    .empty_no(empty_no), .aempty_no(aempty_no)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    wen_ni = 1'b1;
    ren_ni = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_flags(string tag);
    int c = model_q.size();
    chk({"R2 full ", tag},    32'(full_no),   32'(!(c == DEPTH)));
    chk({"R4 empty ", tag},   32'(empty_no),  32'(c != 0));
    chk({"R5 aempty ", tag},  32'(aempty_no), 32'(!(c <= int'(n_ofs))));
    chk({"R6 afull ", tag},   32'(afull_no),  32'(!(c + int'(m_ofs) >= DEPTH)));
    chk({"R7 half ", tag},    32'(half_no),   32'(!(c > DEPTH / 2)));
  endtask

  task automatic wr_burst(int num, logic [DATA_W-1:0] base);
    for (int i = 0; i < num; i++) begin
      wen_ni = 1'b0;
      wdata  = base + DATA_W'(i);
      if (model_q.size() < DEPTH) model_q.push_back(wdata);
      @(negedge clk);
    end
    wen_ni = 1'b1;
  endtask

  task automatic rd_burst(int num, string tag);
    for (int i = 0; i < num; i++) begin
      logic [DATA_W-1:0] exp;
      ren_ni = 1'b0;
      exp = (model_q.size() > 0) ? model_q.pop_front() : last_rd;
      @(negedge clk);
      chk(tag, 32'(rdata), 32'(exp));
      last_rd = exp;
    end
    ren_ni = 1'b1;
  endtask

  task automatic t_reset();
    wr_burst(7, 18'h00700);
    settle();
    rst_ni = 1'b0;
    @(negedge clk);
    model_q.delete();
    last_rd = '0;
    chk("R8 full", 32'(full_no), 32'd1);
    chk("R8 half", 32'(half_no), 32'd1);
    chk("R8 afull", 32'(afull_no), 32'd1);
    chk("R8 empty", 32'(empty_no), 32'd0);
    chk("R8 aempty", 32'(aempty_no), 32'd0);
    chk("R8 rdata", 32'(rdata), 32'd0);
    rst_ni = 1'b1;
    settle();
    check_flags("R8 after reset");
    rd_burst(2, "R8 no stale words");
  endtask

  task automatic t_no_fallthrough();
    wr_burst(1, 18'h00111);
    settle();
    chk("R3 no fall-through", 32'(rdata), 32'(last_rd));
    check_flags("R3 one word");
    rd_burst(1, "R3 explicit read");
    settle();
    check_flags("R4 drained");
    rd_burst(3, "R4 reads ignored when empty");
  endtask

  task automatic t_thresholds();
    n_ofs = 12'd5;
    m_ofs = 12'd10;
    wr_burst(5, 18'h01000);   settle(); check_flags("cnt5");
    wr_burst(1, 18'h01005);   settle(); check_flags("cnt6");
    wr_burst(122, 18'h01006); settle(); check_flags("cnt128");
    wr_burst(1, 18'h01080);   settle(); check_flags("cnt129");
    wr_burst(116, 18'h01081); settle(); check_flags("cnt245");
    wr_burst(1, 18'h010f5);   settle(); check_flags("cnt246");
    wr_burst(10, 18'h010f6);  settle(); check_flags("R1 cnt256");
    wr_burst(3, 18'h3dead);   settle(); check_flags("R2 writes ignored");
    rd_burst(10, "R10 order");  settle(); check_flags("down246");
    rd_burst(1, "R10 order");   settle(); check_flags("down245");
    rd_burst(116, "R10 order"); settle(); check_flags("down129");
    rd_burst(1, "R10 order");   settle(); check_flags("down128");
    rd_burst(122, "R10 order"); settle(); check_flags("down6");
    rd_burst(1, "R10 order");   settle(); check_flags("down5");
    rd_burst(5, "R10 order");   settle(); check_flags("down0");
    rd_burst(2, "R4 ignored after last");
  endtask

  task automatic t_load_block();
    wr_burst(4, 18'h02000);
    settle();
    load_ni = 1'b0;
    wen_ni  = 1'b0;
    ren_ni  = 1'b0;
    wdata   = 18'h3ffff;
    repeat (4) @(negedge clk);
    wen_ni  = 1'b1;
    ren_ni  = 1'b1;
    load_ni = 1'b1;
    settle();
    chk("R9 rdata held", 32'(rdata), 32'(last_rd));
    check_flags("R9 load low");
    rd_burst(6, "R9 contents unchanged");
  endtask

  task automatic t_concurrent();
    wr_burst(50, 18'h03000);
    settle();
    for (int i = 0; i < 100; i++) begin
      logic [DATA_W-1:0] exp;
      wen_ni = 1'b0;
      ren_ni = 1'b0;
      wdata  = 18'h04000 + DATA_W'(i);
      exp    = model_q.pop_front();
      model_q.push_back(wdata);
      @(negedge clk);
      chk("R10 simultaneous", 32'(rdata), 32'(exp));
      last_rd = exp;
    end
    settle();
    check_flags("R10 cnt50");
    rd_burst(50, "R10 drain");
    settle();
    check_flags("R10 empty");
  endtask

  task automatic t_zero_offsets();
    n_ofs = 12'd0;
    m_ofs = 12'd0;
    settle();
    check_flags("R5 n0 empty");
    wr_burst(1, 18'h05000);   settle(); check_flags("R5 n0 one");
    wr_burst(254, 18'h05001); settle(); check_flags("R6 m0 cnt255");
    wr_burst(1, 18'h050ff);   settle(); check_flags("R6 m0 full");
    n_ofs = 12'd127;
    m_ofs = 12'd127;
    settle();
    check_flags("R6 m127 full");
    rd_burst(127, "R10 order");   settle(); check_flags("R6 m127 cnt129");
    rd_burst(2, "R10 order");     settle(); check_flags("R5 n127 cnt127");
    rd_burst(127, "R10 order");   settle(); check_flags("R5 n127 cnt0");
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL R10 watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    settle();
    check_flags("R8 initial");
    chk("R8 initial rdata", 32'(rdata), 32'd0);
    t_reset();
    t_no_fallthrough();
    t_thresholds();
    t_load_block();
    t_concurrent();
    t_zero_offsets();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule